// File: doc/BRIEF.md
# Dual Pseudo-Random Sequence Generator

This block produces two repeating maximal-length pseudo-random bit streams from a single externally supplied data clock: a short stream of period 31 and a long stream of period 255. The data clock is an asynchronous, slow signal. It is brought into the system clock domain, and each of its rising edges advances both streams by one bit.

The short stream is available as a single bit and as a two-bit signed value of +1 or −1. The long stream is available as a single bit only. A frame marker is high for the whole data clock period in which the short stream presents its first bit. A restart input realigns both streams and the marker to their first bit at the same moment. This lets a pattern source for line-coding, modulation or error-count experiments be brought back to a known phase.

Top module: `prbs_dual_gen`

## Requirements
- R1: While and after the synchronous active-high system reset, and before any data clock rising edge, the short and long outputs present bit 0 of their sequences and the frame marker is high.
- R2: The short sequence satisfies s[n+5] = s[n+3] xor s[n]. Its bits 0..4 are the seed 5'b10101 read from the LSB upward, so s[0]=1. It repeats every 31 bits.
- R3: The long sequence satisfies g[n+8] = g[n+6] xor g[n+5] xor g[n+4] xor g[n]. Its bits 0..7 are the seed 8'b10100110 read from the LSB upward, so g[0]=0. It repeats every 255 bits.
- R4: Both sequences advance by exactly one bit per rising edge of the data clock. The data clock is held at each level for at least two system clock cycles. The new bit appears in the third system clock cycle after the edge: two synchroniser flops, then the state register. Falling edges and held levels never advance the sequences.
- R5: The frame marker is high exactly while the short sequence presents bit 0, which is one full data clock period in every 31.
- R6: The signed short output is 2'b01 (+1) when the short bit is 1 and 2'b11 (−1) when it is 0.
- R7: A system clock cycle with the restart input high returns both sequences to bit 0 and raises the frame marker. When that cycle coincides with a synchronised data clock edge, the restart wins and the edge is discarded.
- R8: Neither generator ever reaches the all-zero state. Over one full period the short stream holds 16 ones and the long stream 128 ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high system reset |
| dclk_i | input | 1 | Asynchronous data clock; its rising edges step both sequences |
| restart_i | input | 1 | Synchronous realignment of both sequences to bit 0 |
| short_o | output | 1 | Current bit of the 31-bit sequence |
| short_bip_o | output | 2 | Signed form of the short bit: +1 or −1 |
| long_o | output | 1 | Current bit of the 255-bit sequence |
| sync_o | output | 1 | Frame marker, high while the short sequence is at bit 0 |

## Verification
A restart request and a synchronised data clock edge can land in the same system clock cycle. One asks for bit 0 and the other for the next bit. The bench raises the data clock and then pulses the restart input in the exact cycle in which the synchronised edge becomes active. It expects bit 0 and a high frame marker afterwards, and expects the data clock's later fall to leave them in place. If the edge had been honoured, bit 1 would be visible instead, and the marker would be low.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    // Short generator: recurrence s[n+5] = s[n+3] ^ s[n]
    localparam int              SHORT_W    = 5;
    localparam logic [4:0]      SHORT_TAPS = 5'b01001;
    localparam logic [4:0]      SHORT_SEED = 5'b10101;

    // Long generator: recurrence g[n+8] = g[n+6] ^ g[n+5] ^ g[n+4] ^ g[n]
    localparam int              LONG_W     = 8;
    localparam logic [7:0]      LONG_TAPS  = 8'b0111_0001;
    localparam logic [7:0]      LONG_SEED  = 8'b1010_0110;

    // Derived periods
    localparam int              SHORT_LEN  = (1 << SHORT_W) - 1;
    localparam int              LONG_LEN   = (1 << LONG_W) - 1;

    // Data clock synchroniser depth
    localparam int              SYNC_STAGES = 2;

    typedef logic signed [1:0] bipolar_t;

    typedef struct packed {
        logic short_bit;
        logic long_bit;
        logic frame_start;
    } seq_out_t;

    function automatic bipolar_t to_bipolar(input logic b);
        return b ? 2'sb01 : 2'sb11;
    endfunction

endpackage

// File: rtl/prbs_edge_detect.sv
module prbs_edge_detect #(
    parameter int STAGES = prbs_pkg::SYNC_STAGES
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    // R4: a rising edge yields a single-cycle step, never two in a row
    p_single_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);

endmodule

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
    parameter int           W    = prbs_pkg::SHORT_W,
    parameter logic [W-1:0] TAPS = prbs_pkg::SHORT_TAPS,
    parameter logic [W-1:0] SEED = prbs_pkg::SHORT_SEED
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    input  logic step_i,
    output logic bit_o
);
    logic [W-1:0] state_q;
    logic [W-1:0] state_d;
    logic         fb;

    // state_q[k] holds sequence bit n+k; bit n is presented
    always_comb begin
        fb      = ^(state_q & TAPS);
        state_d = state_q;
        if (restart_i)
            state_d = SEED;
        else if (step_i)
            state_d = {fb, state_q[W-1:1]};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= SEED;
        else       state_q <= state_d;
    end

    assign bit_o = state_q[0];

    // R8: the register never locks up in the all-zero state
    p_nonzero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q != '0);

    // R7: a restart lands the register on its seed
    p_restart_seed_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_i |=> state_q == SEED);

    // R4: without a step or restart the register holds
    p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!step_i && !restart_i) |=> $stable(state_q));

endmodule

// File: rtl/prbs_pos_counter.sv
module prbs_pos_counter #(
    parameter int LEN = prbs_pkg::SHORT_LEN
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    input  logic step_i,
    output logic start_o
);
    localparam int CW = $clog2(LEN);

    logic [CW-1:0] pos_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i)
            pos_q <= '0;
        else if (step_i)
            pos_q <= (pos_q == CW'(LEN - 1)) ? '0 : pos_q + 1'b1;
    end

    assign start_o = (pos_q == '0);

    // R5: position stays inside one period
    p_pos_range_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        pos_q < CW'(LEN));

    // R5: the last position wraps to the frame start on a step
    p_wrap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !restart_i && pos_q == CW'(LEN - 1)) |=> start_o);

endmodule

// File: rtl/prbs_dual_gen.sv
module prbs_dual_gen
    import prbs_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       dclk_i,
    input  logic       restart_i,
    output logic       short_o,
    output logic [1:0] short_bip_o,
    output logic       long_o,
    output logic       sync_o
);
    logic     step;
    seq_out_t seq;

    prbs_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (dclk_i),
        .rise_o  (step)
    );

    prbs_lfsr #(.W(SHORT_W), .TAPS(SHORT_TAPS), .SEED(SHORT_SEED)) u_short (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (restart_i),
        .step_i    (step),
        .bit_o     (seq.short_bit)
    );

    prbs_lfsr #(.W(LONG_W), .TAPS(LONG_TAPS), .SEED(LONG_SEED)) u_long (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (restart_i),
        .step_i    (step),
        .bit_o     (seq.long_bit)
    );

    prbs_pos_counter #(.LEN(SHORT_LEN)) u_pos (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (restart_i),
        .step_i    (step),
        .start_o   (seq.frame_start)
    );

    assign short_o     = seq.short_bit;
    assign long_o      = seq.long_bit;
    assign sync_o      = seq.frame_start;
    assign short_bip_o = to_bipolar(seq.short_bit);

    // R5: frame marker coincides with short bit 0
    p_sync_bit0_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_o |-> short_o == SHORT_SEED[0]);

    // R6: signed output is never zero
    p_bip_nonzero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        short_bip_o != 2'b00);

endmodule

// File: tb/prbs_dual_gen_tb.sv
module prbs_dual_gen_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  SL = 31;
    localparam int  LL = 255;

    logic       clk = 1'b0;
    logic       rst_i, dclk_i, restart_i;
    logic       short_o, long_o, sync_o;
    logic [1:0] short_bip_o;

    prbs_dual_gen u_dut (
        .clk_i(clk), .rst_i(rst_i), .dclk_i(dclk_i), .restart_i(restart_i),
        .short_o(short_o), .short_bip_o(short_bip_o),
        .long_o(long_o), .sync_o(sync_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int k        = 0;
    int ones_s   = 0;
    int ones_l   = 0;
    logic sseq [SL];
    logic lseq [LL];

    typedef struct {
        int due;
        int idx;
        bit tally;
        string req;
    } exp_t;
    exp_t q[$];
    exp_t e;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, string what, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic check_at(string req, int idx);
        logic s;
        s = sseq[idx % SL];
        check(req, "short", int'(short_o), int'(s));
        check(req, "long", int'(long_o), int'(lseq[idx % LL]));
        check(req, "sync", int'(sync_o), int'(idx % SL == 0));
        check("R6", "bipolar", int'(short_bip_o), s ? 1 : 3);
    endtask

    // Monitor: pop expected items when due and compare
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            check_at(e.req, e.idx);
            if (e.tally && e.idx >= 1 && e.idx <= SL) ones_s += int'(short_o);
            if (e.tally && e.idx >= 1 && e.idx <= LL) ones_l += int'(long_o);
        end
    end

    // Driver: one data clock period, with expectations around both edges (R4)
    task automatic data_step(int hi, int lo, bit tally, string req);
        int r, f;
        r = cyc;
        q.push_back('{due: r + 2, idx: k, tally: 1'b0, req: "R4"});
        dclk_i = 1'b1;
        k++;
        q.push_back('{due: r + 3, idx: k, tally: tally, req: req});
        repeat (hi) @(negedge clk);
        f = cyc;
        dclk_i = 1'b0;
        q.push_back('{due: f + 3, idx: k, tally: 1'b0, req: "R4"});
        repeat (lo) @(negedge clk);
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
    endtask

    // R7: plain restart with data clock idle
    task automatic do_restart();
        restart_i = 1'b1;
        @(negedge clk);
        restart_i = 1'b0;
        k = 0;
        q.push_back('{due: cyc + 1, idx: 0, tally: 1'b0, req: "R7"});
        drain();
    endtask

    // R7: restart in the same cycle as the synchronised edge
    task automatic do_collide();
        int f;
        dclk_i = 1'b1;
        repeat (2) @(negedge clk);
        restart_i = 1'b1;
        @(negedge clk);
        restart_i = 1'b0;
        k = 0;
        q.push_back('{due: cyc + 1, idx: 0, tally: 1'b0, req: "R7"});
        repeat (4) @(negedge clk);
        f = cyc;
        dclk_i = 1'b0;
        q.push_back('{due: f + 3, idx: 0, tally: 1'b0, req: "R7"});
        drain();
    endtask

    initial begin
        // Expected sequences from the recurrences and seeds of R2 and R3
        for (int i = 0; i < 5; i++) sseq[i] = 1'((5'b10101 >> i) & 1);
        for (int i = 5; i < SL; i++) sseq[i] = sseq[i-2] ^ sseq[i-5];
        for (int i = 0; i < 8; i++) lseq[i] = 1'((8'b10100110 >> i) & 1);
        for (int i = 8; i < LL; i++) lseq[i] = lseq[i-2] ^ lseq[i-3] ^ lseq[i-4] ^ lseq[i-8];

        rst_i = 1'b1; dclk_i = 1'b0; restart_i = 1'b0;
        repeat (4) @(negedge clk);
        check_at("R1", 0);
        rst_i = 1'b0;
        repeat (3) @(negedge clk);
        check_at("R1", 0);

        // R2 R3 R5: more than one long period, varied duty
        for (int i = 0; i < 300; i++)
            data_step(2 + i % 3, 2 + i % 4, 1'b1, (i % 2 == 0) ? "R2" : "R3");
        drain();
        check("R8", "short ones per period", ones_s, 16);
        check("R8", "long ones per period", ones_l, 128);

        // R4: long high level, one step only
        data_step(25, 3, 1'b0, "R4");
        drain();

        do_restart();
        for (int i = 0; i < 5; i++) data_step(2, 3, 1'b0, "R7");
        drain();

        do_collide();
        for (int i = 0; i < 33; i++) data_step(3, 2, 1'b0, "R5");
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule